// File: doc/BRIEF.md
# Warp Issue Scheduler

The scheduler feeds one SIMD pipeline from a pool of resident warps. Each warp is 32 threads that share one instruction stream. In every cycle the block picks one warp that is ready and presents its ID with an issue strobe. Each cycle picks a different ready warp, so a long memory latency in one warp is covered by useful work from the others. The pipeline after the scheduler has several functional units, so a new warp may issue in every cycle.

The block keeps a small state per warp: not resident, ready, one instruction in flight, or parked on a data-cache miss. A warp may have only one instruction in flight. Because of this, no dependency interlock is needed.

Events from the pipeline move a warp between these states:
- A launch makes a warp resident.
- A writeback completes the warp's instruction. A writeback flagged as last also retires the warp.
- A miss notice from the memory stage parks the warp.
- A fill from the memory stage returns a parked warp to the pool.

The other warps keep issuing while a warp is parked.

Top module: `warp_issue_sched`

## Requirements
- R1: A synchronous active-high reset puts every warp in the not-resident state. While no warp has been launched, `issue_valid` is 0.
- R2: A launch to a not-resident warp makes it ready, and it can issue in the next cycle. A launch to a warp in any other state has no effect.
- R3: Only a ready warp is issued, and at most one warp per cycle. After issue the warp is in flight and is not issued again until a later event returns it to ready.
- R4: The warp issued is the first ready warp found by a cyclic search that begins one index after the most recently issued warp. After reset the search begins at warp 0.
- R5: When no warp is ready, `issue_valid` is 0 and the most recently issued warp remains the starting point of the search.
- R6: A writeback to an in-flight warp makes it ready in the next cycle when `wb_last` is 0. When `wb_last` is 1, the writeback makes the warp not resident.
- R7: A miss notice to an in-flight warp parks it. A parked warp is never issued, and ready warps keep issuing while it is parked.
- R8: A fill to a parked warp makes it ready in the next cycle.
- R9: A miss notice and a writeback to the same in-flight warp in the same cycle park the warp. A writeback or fill to a warp in any state other than the one named in R6 or R8 has no effect, and so does a miss notice to a warp that is not in flight. An ID at or above the warp count also has no effect.
- R10: In every cycle in which at least one warp is ready, a warp is issued, so issue runs back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch event strobe |
| launch_warp | input | 5 | Warp ID to launch |
| wb_valid | input | 1 | Writeback / completion strobe |
| wb_warp | input | 5 | Warp ID of the writeback |
| wb_last | input | 1 | Writeback retires the warp |
| miss_valid | input | 1 | Data-cache miss notice strobe |
| miss_warp | input | 5 | Warp ID that missed |
| fill_valid | input | 1 | Miss data returned strobe |
| fill_warp | input | 5 | Warp ID whose miss returned |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | 5 | ID of the issued warp |

## Verification
A warp state held wrongly shows up at the ports in the cycle after the event that should have moved it. There are three cases:
- A warp that was dropped never appears on `issue_warp`.
- A warp left ready when it should be in flight appears twice while its instruction is still outstanding.
- A warp left parked after its fill stays silent while other warps issue.

A round-robin pointer that is wrong changes the order of issued IDs at the next grant. A pointer that drifts during idle cycles shows up at the first issue after the idle stretch. For this reason the issue sequence is compared with a model in every cycle.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    localparam int MAX_WARPS    = 32;
    localparam int WARP_ID_W    = $clog2(MAX_WARPS);
    localparam int WARP_THREADS = 32;

    typedef logic [WARP_ID_W-1:0] warp_id_t;

    // Life cycle of one resident warp
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,   // not resident
        WS_READY  = 2'd1,   // eligible for issue
        WS_BUSY   = 2'd2,   // one instruction in flight
        WS_PARKED = 2'd3    // waiting for a cache miss to return
    } warp_state_e;

    typedef struct packed {
        logic     valid;
        warp_id_t id;
    } warp_evt_t;

    function automatic logic evt_hits(warp_evt_t e, int unsigned w);
        return e.valid && (e.id == warp_id_t'(w));
    endfunction

endpackage

// File: rtl/ws_warp_table.sv
module ws_warp_table
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  warp_evt_t            launch_e,
    input  warp_evt_t            wb_e,
    input  logic                 wb_last,
    input  warp_evt_t            miss_e,
    input  warp_evt_t            fill_e,
    input  warp_evt_t            issue_e,
    output logic [NUM_WARPS-1:0] ready_vec
);

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        warp_state_e st_q, st_d;

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                WS_IDLE:   if (evt_hits(launch_e, g)) st_d = WS_READY;
                WS_READY:  if (evt_hits(issue_e, g))  st_d = WS_BUSY;
                WS_BUSY: begin
                    if (evt_hits(miss_e, g))     st_d = WS_PARKED;
                    else if (evt_hits(wb_e, g))  st_d = wb_last ? WS_IDLE : WS_READY;
                end
                WS_PARKED: if (evt_hits(fill_e, g)) st_d = WS_READY;
                default:   st_d = WS_IDLE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) st_q <= WS_IDLE;
            else     st_q <= st_d;
        end

        assign ready_vec[g] = (st_q == WS_READY);

        // Picker may only choose this warp while it is ready
        assert_issue_ready_R3: assert property (@(posedge clk) disable iff (rst)
            evt_hits(issue_e, g) |-> st_q == WS_READY);

        assert_issue_busy_R3: assert property (@(posedge clk) disable iff (rst)
            evt_hits(issue_e, g) |=> st_q == WS_BUSY);

        assert_ready_holds_R2: assert property (@(posedge clk) disable iff (rst)
            (st_q == WS_READY && !evt_hits(issue_e, g)) |=> st_q == WS_READY);

        assert_parked_holds_R7: assert property (@(posedge clk) disable iff (rst)
            (st_q == WS_PARKED && !evt_hits(fill_e, g)) |=> st_q == WS_PARKED);

        assert_fill_ready_R8: assert property (@(posedge clk) disable iff (rst)
            (st_q == WS_PARKED && evt_hits(fill_e, g)) |=> st_q == WS_READY);

        assert_miss_wins_R9: assert property (@(posedge clk) disable iff (rst)
            (st_q == WS_BUSY && evt_hits(miss_e, g) && evt_hits(wb_e, g)) |=> st_q == WS_PARKED);

        assert_wb_resume_R6: assert property (@(posedge clk) disable iff (rst)
            (st_q == WS_BUSY && !evt_hits(miss_e, g) && evt_hits(wb_e, g) && !wb_last)
                |=> st_q == WS_READY);
    end

endmodule

// File: rtl/ws_rr_picker.sv
module ws_rr_picker
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] ready_vec,
    output logic                 grant_valid,
    output warp_id_t             grant_id
);

    localparam warp_id_t LAST_INIT = warp_id_t'(NUM_WARPS - 1);

    warp_id_t               last_q;
    logic [MAX_WARPS-1:0]   rdy_ext;

    assign rdy_ext = MAX_WARPS'(ready_vec);

    // Cyclic search starting one past the last issued warp
    always_comb begin
        warp_id_t idx;
        grant_valid = 1'b0;
        grant_id    = '0;
        idx         = '0;
        for (int step = 1; step <= NUM_WARPS; step++) begin
            idx = warp_id_t'((int'(last_q) + step) % NUM_WARPS);
            if (!grant_valid && rdy_ext[idx]) begin
                grant_valid = 1'b1;
                grant_id    = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              last_q <= LAST_INIT;
        else if (grant_valid) last_q <= grant_id;
    end

    assert_grant_ready_R3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> rdy_ext[grant_id]);

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !grant_valid |=> $stable(last_q));

    assert_no_bubble_R10: assert property (@(posedge clk) disable iff (rst)
        (ready_vec != '0) |-> grant_valid);

    assert_no_repeat_R4: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && $countones(ready_vec) > 1) |-> grant_id != last_q);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       launch_valid,
    input  logic [4:0] launch_warp,
    input  logic       wb_valid,
    input  logic [4:0] wb_warp,
    input  logic       wb_last,
    input  logic       miss_valid,
    input  logic [4:0] miss_warp,
    input  logic       fill_valid,
    input  logic [4:0] fill_warp,
    output logic       issue_valid,
    output logic [4:0] issue_warp
);

    warp_evt_t            launch_e, wb_e, miss_e, fill_e, issue_e;
    logic [NUM_WARPS-1:0] ready_vec;
    logic                 grant_valid;
    warp_id_t             grant_id;

    assign launch_e = '{valid: launch_valid, id: launch_warp};
    assign wb_e     = '{valid: wb_valid,     id: wb_warp};
    assign miss_e   = '{valid: miss_valid,   id: miss_warp};
    assign fill_e   = '{valid: fill_valid,   id: fill_warp};
    assign issue_e  = '{valid: grant_valid,  id: grant_id};

    ws_warp_table #(.NUM_WARPS(NUM_WARPS)) u_table (
        .clk       (clk),
        .rst       (rst),
        .launch_e  (launch_e),
        .wb_e      (wb_e),
        .wb_last   (wb_last),
        .miss_e    (miss_e),
        .fill_e    (fill_e),
        .issue_e   (issue_e),
        .ready_vec (ready_vec)
    );

    ws_rr_picker #(.NUM_WARPS(NUM_WARPS)) u_pick (
        .clk         (clk),
        .rst         (rst),
        .ready_vec   (ready_vec),
        .grant_valid (grant_valid),
        .grant_id    (grant_id)
    );

    assign issue_valid = grant_valid;
    assign issue_warp  = grant_id;

    assert_issue_range_R3: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> int'(issue_warp) < NUM_WARPS);

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> !issue_valid);

endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;

    localparam int NW = 32;
    localparam int S_IDLE = 0, S_READY = 1, S_BUSY = 2, S_PARKED = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       launch_valid = 0, wb_valid = 0, wb_last = 0, miss_valid = 0, fill_valid = 0;
    logic [4:0] launch_warp = 0, wb_warp = 0, miss_warp = 0, fill_warp = 0;
    logic       issue_valid;
    logic [4:0] issue_warp;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int mst[NW];
    int mptr;

    always #2 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW)) dut (
        .clk(clk), .rst(rst),
        .launch_valid(launch_valid), .launch_warp(launch_warp),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_last(wb_last),
        .miss_valid(miss_valid), .miss_warp(miss_warp),
        .fill_valid(fill_valid), .fill_warp(fill_warp),
        .issue_valid(issue_valid), .issue_warp(issue_warp)
    );

    // Cyclic search after the last issued warp (R4)
    function automatic int model_pick();
        for (int s = 1; s <= NW; s++) begin
            int idx = (mptr + s) % NW;
            if (mst[idx] == S_READY) return idx;
        end
        return -1;
    endfunction

    function automatic int find_state(int want, int start);
        for (int s = 0; s < NW; s++) begin
            int idx = (start + s) % NW;
            if (mst[idx] == want) return idx;
        end
        return -1;
    endfunction

    task automatic model_update();
        int pick = model_pick();
        int nxt[NW];
        for (int w = 0; w < NW; w++) begin
            nxt[w] = mst[w];
            case (mst[w])
                S_IDLE:   if (launch_valid && launch_warp == w) nxt[w] = S_READY;
                S_READY:  if (pick == w) nxt[w] = S_BUSY;
                S_BUSY: begin
                    if (miss_valid && miss_warp == w)  nxt[w] = S_PARKED;
                    else if (wb_valid && wb_warp == w) nxt[w] = wb_last ? S_IDLE : S_READY;
                end
                default:  if (fill_valid && fill_warp == w) nxt[w] = S_READY;
            endcase
        end
        for (int w = 0; w < NW; w++) mst[w] = nxt[w];
        if (pick >= 0) mptr = pick;
    endtask

    task automatic check_issue(string tag);
        int  exp_id = model_pick();
        bit  exp_v  = (exp_id >= 0);
        total++;
        if (issue_valid !== exp_v || (exp_v && issue_warp !== 5'(exp_id))) begin
            bad++;
            $display("FAIL %s: issue_valid=%0b issue_warp=%0d expected valid=%0b warp=%0d",
                     tag, issue_valid, issue_warp, exp_v, exp_id);
        end
    endtask

    task automatic clear_inputs();
        launch_valid = 0; wb_valid = 0; wb_last = 0; miss_valid = 0; fill_valid = 0;
    endtask

    task automatic tick(string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        check_issue(tag);
    endtask

    task automatic do_launch(int w); launch_valid = 1; launch_warp = 5'(w); endtask
    task automatic do_wb(int w, bit last); wb_valid = 1; wb_warp = 5'(w); wb_last = last; endtask
    task automatic do_miss(int w); miss_valid = 1; miss_warp = 5'(w); endtask
    task automatic do_fill(int w); fill_valid = 1; fill_warp = 5'(w); endtask

    // Random events; pmiss/plaunch in percent
    task automatic random_phase(int cycles, int plaunch, int pmiss, int pstray);
        for (int c = 0; c < cycles; c++) begin
            int b, p;
            if ($urandom_range(99) < plaunch) do_launch($urandom_range(NW - 1));
            b = find_state(S_BUSY, $urandom_range(NW - 1));
            if (b >= 0 && $urandom_range(99) < 50) begin
                if ($urandom_range(99) < pmiss) begin
                    do_miss(b);
                    if ($urandom_range(3) == 0) do_wb(b, 0);
                end else begin
                    do_wb(b, $urandom_range(7) == 0);
                end
            end
            p = find_state(S_PARKED, $urandom_range(NW - 1));
            if (p >= 0 && $urandom_range(99) < 30) do_fill(p);
            if ($urandom_range(99) < pstray) begin
                // events aimed at arbitrary warps, mostly in wrong states (R9)
                if (!fill_valid) do_fill($urandom_range(31));
                else if (!miss_valid) do_miss($urandom_range(31));
            end
            tick(model_pick() >= 0 ? "R4/R10" : "R5");
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int seed_sink;
        seed_sink = $urandom(32'd20240611);
        for (int w = 0; w < NW; w++) mst[w] = S_IDLE;
        mptr = NW - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_issue("R1");
        tick("R1");

        // R2: launch, then issue in the next cycle
        do_launch(5);  tick("R2");
        do_launch(5);  tick("R3");      // issued -> busy, launch ignored
        do_launch(5);  tick("R2");      // launch on busy ignored
        do_fill(5);    tick("R9");      // fill on busy ignored
        do_wb(5, 0);   tick("R6");      // ready again
        tick("R3");                     // issued, now busy
        do_miss(5);    tick("R7");      // parked
        do_wb(5, 0);   tick("R9");      // writeback on parked ignored
        do_fill(5);    tick("R8");      // ready again
        tick("R3");
        do_miss(5); do_wb(5, 0); tick("R9");  // miss wins
        do_fill(5);    tick("R8");
        tick("R3");
        do_wb(5, 1);   tick("R6");      // retired
        do_fill(5);    tick("R9");
        do_launch(5);  tick("R2");
        tick("R3");
        do_launch(31); tick("R9");      // ID 31 is valid in the default build
        tick("R3");

        // R4 / R7 / R10: several warps cycling, one parked
        do_launch(2);  tick("R4");
        do_launch(9);  tick("R4");
        do_launch(30); tick("R4");
        for (int k = 0; k < 12; k++) begin
            int b = find_state(S_BUSY, k);
            if (b == 9 && k < 6) do_miss(b);
            else if (b >= 0) do_wb(b, 0);
            tick("R7/R10");
        end
        do_fill(9); tick("R8");
        for (int k = 0; k < 6; k++) begin
            int b = find_state(S_BUSY, k * 5);
            if (b >= 0) do_wb(b, 1);
            tick("R4");
        end
        // R5: idle stretch then check restart point
        for (int k = 0; k < 8; k++) begin
            int b = find_state(S_BUSY, 0);
            if (b >= 0) do_wb(b, 1);
            tick("R5");
        end
        do_launch(0); tick("R5");
        tick("R5");

        random_phase(3000, 20, 20, 10);
        random_phase(3000, 60, 60, 20);
        random_phase(2000, 3, 30, 5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule